// File: doc/BRIEF.md
# Blink and Heartbeat Duty Modulator

This block is the per-channel engine that decides which duty cycle a PWM channel uses in each pulse cycle. It receives two duty settings (a primary level and a secondary level), two 16-bit timing parameters, a blink enable, a ramp (heartbeat) enable and a strobe that marks the start of each PWM pulse cycle. From these it produces the active duty value that the pulse generator downstream compares against its phase counter.

The block has three modes. In fixed mode the primary level passes straight through. In blink mode the output dwells on the primary level for a programmed number of pulse cycles, then on the secondary level for another programmed number, and repeats. In ramp mode the same two timing parameters take a different meaning: one sets how many pulse cycles pass between steps, the other sets the step size. The duty then walks linearly from the primary level to the secondary level and back, clamping at each end.

Top module: `blink_duty_engine`

## Requirements
- R1: With the blink enable low, duty_out equals duty_a in every cycle, follows changes of duty_a at once, and cycle_start pulses have no effect on it, whatever ramp_en is.
- R2: With blink_en high and ramp_en low, after k strobes since entering the mode duty_out is duty_a when k mod (dwell_x+dwell_y+2) is below dwell_x+1, and duty_b otherwise.
- R3: Internal counters and the output advance only in cycles where cycle_start is high; any number of cycles without a strobe leaves duty_out unchanged.
- R4: Dropping blink_en returns duty_out to duty_a at once; raising it again restarts the pattern from k = 0.
- R5: With blink_en and ramp_en high, duty_out starts at duty_a and takes one step after every dwell_x+1 strobes, each step of size dwell_y+1.
- R6: In ramp mode the first leg ascends when duty_b is greater than duty_a and descends when duty_b is less than duty_a.
- R7: A step that would reach or pass the far end lands exactly on it (duty_b on the outward leg, duty_a on the return leg) and the ramp direction reverses.
- R8: Ramp steps near 0 and near the top of the 16-bit range never wrap, including a step size of 65536.
- R9: In ramp mode with duty_a equal to duty_b, duty_out stays at duty_a for every strobe.
- R10: After reset with blink_en low, duty_out equals duty_a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | One-cycle strobe at the start of each PWM pulse cycle |
| blink_en | input | 1 | Enables blink or ramp modulation |
| ramp_en | input | 1 | Selects ramp instead of square blinking when blink_en is high |
| duty_a | input | 16 | Primary duty level |
| duty_b | input | 16 | Secondary duty level |
| dwell_x | input | 16 | Blink: primary dwell minus one; ramp: strobes between steps minus one |
| dwell_y | input | 16 | Blink: secondary dwell minus one; ramp: step size minus one |
| duty_out | output | 16 | Active duty cycle for the current pulse cycle |

## Verification
The bench sweeps small dwell values in blink mode and compares every strobe against a closed-form position within the period, so an off-by-one in either dwell would shift the switch points. Ramp cases cover ascending, descending, an exact landing, an overshooting last step, equal levels and the extremes of the 16-bit range; a design that let the sum wrap would jump to a low value near 65535 and a design that forgot to clamp would pass beyond the end before turning. Gaps without strobes and a mid-pattern drop of the enable catch designs that advance on every clock or that resume instead of restarting.

// File: rtl/bde_pkg.sv
package bde_pkg;

  typedef enum logic [1:0] {
    MODE_FIXED = 2'd0,
    MODE_BLINK = 2'd1,
    MODE_RAMP  = 2'd2
  } bde_mode_e;

  function automatic bde_mode_e decode_mode(input logic blink, input logic ramp);
    if (!blink)    return MODE_FIXED;
    else if (ramp) return MODE_RAMP;
    else           return MODE_BLINK;
  endfunction

endpackage

// File: rtl/bde_leg_counter.sv
module bde_leg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             strobe,
  input  logic [CNT_W-1:0] limit,
  output logic             term,
  output logic [CNT_W-1:0] count
);

  logic at_limit;
  assign at_limit = (count == limit);
  assign term     = strobe && !clear && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (clear)      count <= '0;
    else if (strobe) begin
      if (at_limit)      count <= '0;
      else               count <= count + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !strobe) |=> $stable(count)); // R3

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0)); // R4

endmodule

// File: rtl/bde_blink_phase.sv
module bde_blink_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic term,
  output logic on_b
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     on_b <= 1'b0;
    else if (clear) on_b <= 1'b0;
    else if (term)  on_b <= ~on_b;
  end

  AST_PHASE_ON_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !term) |=> $stable(on_b)); // R2

endmodule

// File: rtl/bde_ramp.sv
module bde_ramp #(
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [DUTY_W-1:0] duty_a,
  input  logic [DUTY_W-1:0] duty_b,
  input  logic [DUTY_W-1:0] step_m1,
  output logic [DUTY_W-1:0] level
);

  localparam int SUM_W = DUTY_W + 1;

  // Returns {reached, next}; SUM_W-bit math keeps the step from wrapping.
  function automatic logic [DUTY_W:0] advance(
    input logic [DUTY_W-1:0] cur,
    input logic [DUTY_W-1:0] target,
    input logic [SUM_W-1:0]  amt,
    input logic              up
  );
    logic [SUM_W-1:0] wide;
    logic             reached;
    if (up) begin
      wide    = {1'b0, cur} + amt;
      reached = (wide >= {1'b0, target});
    end else if (amt > {1'b0, cur}) begin
      wide    = '0;
      reached = 1'b1;
    end else begin
      wide    = {1'b0, cur} - amt;
      reached = (wide <= {1'b0, target});
    end
    if (reached) return {1'b1, target};
    else         return {1'b0, wide[DUTY_W-1:0]};
  endfunction

  logic                  toward_b;
  logic                  ascend_ab;
  logic                  going_up;
  logic [DUTY_W-1:0]     target;
  logic [SUM_W-1:0]      amt;
  logic [DUTY_W:0]       nxt;
  logic                  turn_evt;

  assign ascend_ab = (duty_b >= duty_a);
  assign going_up  = toward_b ? ascend_ab : !ascend_ab;
  assign target    = toward_b ? duty_b : duty_a;
  assign amt       = {1'b0, step_m1} + 1'b1;
  assign nxt       = advance(level, target, amt, going_up);
  assign turn_evt  = step && nxt[DUTY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level    <= '0;
      toward_b <= 1'b1;
    end else if (clear) begin
      level    <= duty_a;
      toward_b <= 1'b1;
    end else if (step) begin
      level <= nxt[DUTY_W-1:0];
      if (turn_evt) toward_b <= ~toward_b;
    end
  end

  AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(level)); // R5

  AST_TURN_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && turn_evt) |=> (level == $past(target))); // R7

endmodule

// File: rtl/blink_duty_engine.sv
module blink_duty_engine #(
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_start,
  input  logic              blink_en,
  input  logic              ramp_en,
  input  logic [DUTY_W-1:0] duty_a,
  input  logic [DUTY_W-1:0] duty_b,
  input  logic [DUTY_W-1:0] dwell_x,
  input  logic [DUTY_W-1:0] dwell_y,
  output logic [DUTY_W-1:0] duty_out
);
  import bde_pkg::*;

  localparam int CNT_W = DUTY_W;

  bde_mode_e         mode, mode_q;
  logic              mode_change;
  logic              cnt_clear;
  logic              term;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  limit;
  logic              on_b;
  logic [DUTY_W-1:0] ramp_level;

  assign mode        = decode_mode(blink_en, ramp_en);
  assign mode_change = (mode != mode_q);
  assign cnt_clear   = (mode == MODE_FIXED) || mode_change;
  assign limit       = (mode == MODE_BLINK && on_b) ? dwell_y : dwell_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_FIXED;
    else        mode_q <= mode;
  end

  bde_leg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cnt_clear),
    .strobe (cycle_start),
    .limit  (limit),
    .term   (term),
    .count  (count)
  );

  bde_blink_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (mode != MODE_BLINK || mode_change),
    .term  (term),
    .on_b  (on_b)
  );

  bde_ramp #(.DUTY_W(DUTY_W)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (mode != MODE_RAMP || mode_change),
    .step    (term && mode == MODE_RAMP),
    .duty_a  (duty_a),
    .duty_b  (duty_b),
    .step_m1 (dwell_y),
    .level   (ramp_level)
  );

  always_comb begin
    unique case (mode)
      MODE_BLINK: duty_out = on_b ? duty_b : duty_a;
      MODE_RAMP:  duty_out = ramp_level;
      default:    duty_out = duty_a;
    endcase
  end

  AST_COUNT_IN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!blink_en && $past(!blink_en)) |-> (count == '0)); // R1

endmodule

// File: tb/blink_duty_engine_test.sv
module blink_duty_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cycle_start = 1'b0;
  logic        blink_en = 1'b0;
  logic        ramp_en = 1'b0;
  logic [15:0] duty_a = 16'd0;
  logic [15:0] duty_b = 16'd0;
  logic [15:0] dwell_x = 16'd0;
  logic [15:0] dwell_y = 16'd0;
  logic [15:0] duty_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  blink_duty_engine uut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .blink_en(blink_en), .ramp_en(ramp_en),
    .duty_a(duty_a), .duty_b(duty_b),
    .dwell_x(dwell_x), .dwell_y(dwell_y),
    .duty_out(duty_out)
  );

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(duty_out) != exp) begin
      errors++;
      $display("FAIL %s duty_out=%0d expected=%0d", req, duty_out, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) cycle_start = 1'b1;
    @(negedge clk) cycle_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_blink(int k, int a, int b, int x, int y);
    return ((k % (x + y + 2)) < (x + 1)) ? a : b;
  endfunction

  function automatic int exp_ramp(int k, int a, int b, int x, int y);
    int n = k / (x + 1);
    int s = y + 1;
    int d = (b >= a) ? b - a : a - b;
    int m = (d + s - 1) / s;
    int p;
    if (m == 0) return a;
    p = n % (2 * m);
    if (p == m) return b;
    if (p < m)  return (b >= a) ? a + p * s : a - p * s;
    return (b >= a) ? b - (p - m) * s : b + (p - m) * s;
  endfunction

  task automatic enter(input bit ramp, input int a, input int b, input int x, input int y);
    @(negedge clk);
    blink_en = 1'b0; ramp_en = ramp;
    duty_a = a[15:0]; duty_b = b[15:0]; dwell_x = x[15:0]; dwell_y = y[15:0];
    idle(2);
    blink_en = 1'b1;
    idle(1);
  endtask

  task automatic run_ramp(input string req, input int a, input int b, input int x, input int y, input int n);
    enter(1'b1, a, b, x, y);
    check(req, a);
    for (int k = 1; k <= n; k++) begin
      strobe();
      check(req, exp_ramp(k, a, b, x, y));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    duty_a = 16'd321;
    idle(3);
    check("R10", 321);
    rst_n = 1'b1;
    idle(2);
    check("R10", 321);

    // R1: fixed mode, strobes ignored, live tracking, ramp_en irrelevant
    duty_b = 16'd999; dwell_x = 0; dwell_y = 0;
    for (int r = 0; r < 2; r++) begin
      ramp_en = r[0];
      for (int k = 0; k < 4; k++) begin
        strobe();
        check("R1", 321);
      end
    end
    @(negedge clk) duty_a = 16'd4444;
    #1 check("R1", 4444);

    // R2: blink sweep over small dwell values
    for (int x = 0; x < 3; x++)
      for (int y = 0; y < 3; y++) begin
        enter(1'b0, 100, 900, x, y);
        check("R2", 100);
        for (int k = 1; k <= 14; k++) begin
          strobe();
          check("R2", exp_blink(k, 100, 900, x, y));
        end
      end

    // R3: gaps between strobes hold the output
    enter(1'b0, 10, 20, 1, 1);
    for (int k = 1; k <= 8; k++) begin
      strobe();
      idle(k);
      check("R3", exp_blink(k, 10, 20, 1, 1));
    end

    // R4: drop enable mid-pattern, then restart from k = 0
    enter(1'b0, 7, 77, 0, 2);
    strobe(); strobe();
    check("R4", 77);
    @(negedge clk) blink_en = 1'b0;
    #1 check("R4", 7);
    idle(2);
    blink_en = 1'b1;
    idle(1);
    for (int k = 1; k <= 6; k++) begin
      strobe();
      check("R4", exp_blink(k, 7, 77, 0, 2));
    end

    // R5 / R6 / R7: ramps
    run_ramp("R5", 100, 130, 0, 9, 14);
    run_ramp("R5", 100, 130, 2, 9, 20);
    run_ramp("R6", 130, 100, 1, 9, 16);
    run_ramp("R7", 100, 135, 0, 9, 20);
    run_ramp("R7", 200, 163, 0, 9, 20);
    run_ramp("R9", 50, 50, 0, 3, 6);
    // R8: range extremes
    run_ramp("R8", 65530, 65535, 0, 9, 6);
    run_ramp("R8", 5, 0, 0, 9, 6);
    run_ramp("R8", 0, 65535, 0, 65535, 6);
    run_ramp("R8", 65535, 0, 0, 65535, 6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule